// File: doc/BRIEF.md
# GPIO edge-detect interrupt unit

This unit watches 28 general-purpose input pins, passes each through a two-flop synchronizer and latches selected transitions into a sticky pending register. Each pin has two enable bits, one for rising and one for falling transitions. Setting both enable bits makes either direction latch the pin's pending bit. Software clears pending bits by writing ones to them. A write-back of the value just read therefore clears everything that was observed.

The lowest 11 pins each drive their own interrupt line straight from their pending bit. The remaining 17 pins share one summary line, which is the OR of their pending bits. A handler reads the pending register, keeps bits 11 and up, clears them and repeats while the summary line stays high. A separate wake mask picks the pins that may still latch events while the system sleeps. In sleep, only those pins can raise the wake request.

Software reaches the unit over a minimal register bus: a word address, write data, a write strobe and combinational read data.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the rising-enable, falling-enable, pending and wake-mask registers all read 0, and every interrupt output and the wake request are low.
- R2: With only the rising enable set for a pin, a 0-to-1 transition sets its pending bit and a 1-to-0 transition does not.
- R3: With only the falling enable set for a pin, a 1-to-0 transition sets its pending bit and a 0-to-1 transition does not.
- R4: With both enables set, a transition in either direction sets the pending bit.
- R5: A pin with neither enable set never sets its pending bit, whatever it does.
- R6: Writing the pending register (offset 0x8) clears exactly the bits written as 1. Bits written as 0 keep their value, and writing back the value read clears all pending bits.
- R7: A pending bit stays set after its pin returns to its former level, until software clears it.
- R8: Interrupt output irq_direct[i] equals pending bit i, for i from 0 to 10.
- R9: irq_summary is high exactly when any pending bit from 11 to 27 is set. It rises again when such a bit is set after being cleared.
- R10: When a qualifying transition and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R11: While sleep_mode is high, only pins whose wake-mask bit and matching edge enable are both set can set pending bits. wake_req is high only in sleep, when a wake-masked pending bit is set.
- R12: The rising-enable register is at offset 0x0, falling-enable at 0x4, pending at 0x8 and wake-mask at 0xC. Read data bits 31 to 28 are always 0.
- R13: A pin change made between two clock edges shows in the pending register after the third following rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 28 | Asynchronous pin levels |
| sleep_mode | input | 1 | High while the system sleeps |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_direct | output | 11 | Per-pin interrupts for pins 0 to 10 |
| irq_summary | output | 1 | OR of pending bits 11 to 27 |
| wake_req | output | 1 | Wake request during sleep |

## Verification
Single pins are driven through rising and falling transitions under each of the four enable settings. This separates a swapped or ignored enable from correct edge selection, and a level-triggered latch from an edge-triggered one. A group of low and high pins that fire together, followed by partial, empty and write-back clears, shows whether clearing reaches only the addressed bits and whether routing reaches the right output. A transition lined up cycle-exactly with a clearing write tells set-priority from clear-priority. A sleep sequence in which a masked pin and an unmasked pin both toggle tells the wake qualification apart from plain edge detection.

// File: rtl/gpio_edge_pkg.sv
// Package: shared constants and register selector for the GPIO edge unit.
// Assumes word-aligned register offsets decoded from address bits [3:2].
package gpio_edge_pkg;
    localparam int PIN_COUNT    = 28;
    localparam int DIRECT_COUNT = 11;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 4;
    localparam int SEL_LSB      = 2;

    typedef enum logic [1:0] {
        SEL_RISE = 2'd0,
        SEL_FALL = 2'd1,
        SEL_PEND = 2'd2,
        SEL_WAKE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Brings each pin into the clock domain through two flops, keeps one more
// delayed copy and flags rising and falling transitions for one cycle.
// Assumes pins are quasi-static compared with the clock period.
module gpio_pin_sync #(
    parameter int PIN_COUNT = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pin_raw,
    output logic [PIN_COUNT-1:0] rise_vec,
    output logic [PIN_COUNT-1:0] fall_vec
);
    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;

        // Purpose: two-stage synchronizer plus one-cycle history per pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_raw[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign rise_vec[g] = sync_q & ~prev_q;
        assign fall_vec[g] = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_regs.sv
// Module: gpio_regs
// Holds the rising-enable, falling-enable and wake-mask registers, decodes
// writes, produces the pending clear vector and muxes read data.
// Assumes one access per cycle; unused upper data bits read as zero.
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int PIN_W  = PIN_COUNT,
    parameter int DWIDTH = DATA_W,
    parameter int AWIDTH = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AWIDTH-1:0] bus_addr,
    input  logic [DWIDTH-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [PIN_W-1:0]  pend_q,
    output logic [PIN_W-1:0]  rise_en,
    output logic [PIN_W-1:0]  fall_en,
    output logic [PIN_W-1:0]  wake_en,
    output logic [PIN_W-1:0]  clr_vec,
    output logic [DWIDTH-1:0] bus_rdata
);
    reg_sel_e         sel;
    logic [PIN_W-1:0] wr_bits;
    logic             unused_bits;

    assign sel         = reg_sel_e'(bus_addr[SEL_LSB+1:SEL_LSB]);
    assign wr_bits     = bus_wdata[PIN_W-1:0];
    assign unused_bits = ^{bus_wdata[DWIDTH-1:PIN_W], bus_addr[SEL_LSB-1:0]};

    // Purpose: update the enable and wake registers on addressed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            wake_en <= '0;
        end else if (bus_we) begin
            if (sel == SEL_RISE) rise_en <= wr_bits;
            if (sel == SEL_FALL) fall_en <= wr_bits;
            if (sel == SEL_WAKE) wake_en <= wr_bits;
        end
    end

    // Purpose: a write to the pending register clears the bits written as 1.
    always_comb begin
        clr_vec = '0;
        if (bus_we && sel == SEL_PEND) clr_vec = wr_bits;
    end

    // Purpose: select the addressed register, upper bits forced to zero.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_RISE: bus_rdata[PIN_W-1:0] = rise_en;
            SEL_FALL: bus_rdata[PIN_W-1:0] = fall_en;
            SEL_PEND: bus_rdata[PIN_W-1:0] = pend_q;
            SEL_WAKE: bus_rdata[PIN_W-1:0] = wake_en;
            default:  bus_rdata = '0;
        endcase
    end

    // R1
    enables_clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rise_en == '0 && fall_en == '0 && wake_en == '0));
endmodule

// File: rtl/gpio_edge_status.sv
// Module: gpio_edge_status
// Qualifies transitions with the edge enables (and the wake mask in sleep)
// and keeps the sticky pending register. Clears come from register writes;
// a set in the same cycle as a clear wins.
module gpio_edge_status #(
    parameter int PIN_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_mode,
    input  logic [PIN_W-1:0] rise_vec,
    input  logic [PIN_W-1:0] fall_vec,
    input  logic [PIN_W-1:0] rise_en,
    input  logic [PIN_W-1:0] fall_en,
    input  logic [PIN_W-1:0] wake_en,
    input  logic [PIN_W-1:0] clr_vec,
    output logic [PIN_W-1:0] set_vec,
    output logic [PIN_W-1:0] pend_q
);
    logic [PIN_W-1:0] gate;

    // Purpose: in sleep only wake-masked pins may latch events.
    assign gate    = sleep_mode ? wake_en : '1;
    assign set_vec = gate & ((rise_vec & rise_en) | (fall_vec & fall_en));

    // Purpose: sticky pending bits, write-1-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    // R6
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

    // R11
    sleep_gates_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_mode |-> ((set_vec & ~wake_en) == '0));
endmodule

// File: rtl/gpio_irq_route.sv
// Module: gpio_irq_route
// Maps pending bits onto the per-pin lines, the shared summary line and the
// wake request. Purely combinational; assumes DIRECT_N < PIN_W.
module gpio_irq_route #(
    parameter int PIN_W    = 28,
    parameter int DIRECT_N = 11
) (
    input  logic                pend_q,
    input  logic [PIN_W-1:0]    pend_vec,
    input  logic [PIN_W-1:0]    wake_en,
    input  logic                sleep_mode,
    output logic [DIRECT_N-1:0] irq_direct,
    output logic                irq_summary,
    output logic                wake_req
);
    logic unused_flag;
    assign unused_flag = pend_q;

    for (genvar g = 0; g < DIRECT_N; g++) begin : g_direct
        assign irq_direct[g] = pend_vec[g];
    end

    // Purpose: shared line for the upper pins, and qualified wake request.
    assign irq_summary = |pend_vec[PIN_W-1:DIRECT_N];
    assign wake_req    = sleep_mode & (|(pend_vec & wake_en));
endmodule

// File: rtl/gpio_edge_irq.sv
// Module: gpio_edge_irq (top)
// GPIO edge-detect interrupt unit: synchronizer, register file, pending
// register and interrupt routing. Assumes a single clock and that software
// clears stale pending bits before entering sleep.
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int PIN_N    = PIN_COUNT,
    parameter int DIRECT_N = DIRECT_COUNT,
    parameter int DWIDTH   = DATA_W,
    parameter int AWIDTH   = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PIN_N-1:0]    pin_in,
    input  logic                sleep_mode,
    input  logic [AWIDTH-1:0]   bus_addr,
    input  logic [DWIDTH-1:0]   bus_wdata,
    input  logic                bus_we,
    output logic [DWIDTH-1:0]   bus_rdata,
    output logic [DIRECT_N-1:0] irq_direct,
    output logic                irq_summary,
    output logic                wake_req
);
    logic [PIN_N-1:0] rise_vec, fall_vec;
    logic [PIN_N-1:0] rise_en, fall_en, wake_en;
    logic [PIN_N-1:0] clr_vec, set_vec, pend_q;

    gpio_pin_sync #(.PIN_COUNT(PIN_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .rise_vec (rise_vec),
        .fall_vec (fall_vec)
    );

    gpio_regs #(.PIN_W(PIN_N), .DWIDTH(DWIDTH), .AWIDTH(AWIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .pend_q    (pend_q),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .wake_en   (wake_en),
        .clr_vec   (clr_vec),
        .bus_rdata (bus_rdata)
    );

    gpio_edge_status #(.PIN_W(PIN_N)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_mode (sleep_mode),
        .rise_vec   (rise_vec),
        .fall_vec   (fall_vec),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .wake_en    (wake_en),
        .clr_vec    (clr_vec),
        .set_vec    (set_vec),
        .pend_q     (pend_q)
    );

    gpio_irq_route #(.PIN_W(PIN_N), .DIRECT_N(DIRECT_N)) u_route (
        .pend_q      (1'b0),
        .pend_vec    (pend_q),
        .wake_en     (wake_en),
        .sleep_mode  (sleep_mode),
        .irq_direct  (irq_direct),
        .irq_summary (irq_summary),
        .wake_req    (wake_req)
    );

    // R9
    summary_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_summary) |-> $past(|set_vec[PIN_N-1:DIRECT_N]));

    // R11
    wake_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> sleep_mode);

    // R8
    direct_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_direct[0]) |-> $past(set_vec[0]));
endmodule

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
    localparam logic [3:0] A_RISE = 4'h0;
    localparam logic [3:0] A_FALL = 4'h4;
    localparam logic [3:0] A_PEND = 4'h8;
    localparam logic [3:0] A_WAKE = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] pin_in = '0;
    logic        sleep_mode = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [10:0] irq_direct;
    logic        irq_summary;
    logic        wake_req;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_edge_irq u_gpio_edge_irq (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sleep_mode(sleep_mode),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq_direct(irq_direct),
        .irq_summary(irq_summary), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    // drive pins, then wait three rising edges and sit in the low phase
    task automatic pins(input logic [27:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic clean();
        wr(A_RISE, 32'h0); wr(A_FALL, 32'h0); wr(A_WAKE, 32'h0);
        wr(A_PEND, 32'hFFFF_FFFF);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        rd(A_RISE, d); chk("R1 rise_en", d, 0);
        rd(A_FALL, d); chk("R1 fall_en", d, 0);
        rd(A_PEND, d); chk("R1 pending", d, 0);
        rd(A_WAKE, d); chk("R1 wake mask", d, 0);
        chk("R1 irq_direct", {21'b0, irq_direct}, 0);
        chk("R1 irq_summary", {31'b0, irq_summary}, 0);
        chk("R1 wake_req", {31'b0, wake_req}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(A_RISE, 32'hFFFF_FFFF);
        @(negedge clk); rd(A_RISE, d); chk("R12 upper bits zero", d, 32'h0FFF_FFFF);
        wr(A_RISE, 32'h0000_00A5);
        wr(A_FALL, 32'h0000_5A00);
        wr(A_WAKE, 32'h0123_4567);
        @(negedge clk);
        rd(A_RISE, d); chk("R12 offset 0x0", d, 32'h0000_00A5);
        rd(A_FALL, d); chk("R12 offset 0x4", d, 32'h0000_5A00);
        rd(A_WAKE, d); chk("R12 offset 0xC", d, 32'h0123_4567);
        rd(A_PEND, d); chk("R12 offset 0x8", d, 32'h0);
        clean();
    endtask

    task automatic t_single_edges();
        logic [31:0] d;
        wr(A_RISE, 32'h8);
        @(negedge clk); pin_in = 28'h8;
        repeat (2) @(negedge clk);
        rd(A_PEND, d); chk("R13 not after two edges", d, 0);
        @(negedge clk);
        rd(A_PEND, d); chk("R13 R2 set after three edges", d, 32'h8);
        chk("R8 direct line 3", {21'b0, irq_direct}, 32'h8);
        pins(28'h0);
        rd(A_PEND, d); chk("R7 R2 stays after fall", d, 32'h8);
        wr(A_PEND, 32'h8);
        @(negedge clk); rd(A_PEND, d); chk("R6 single clear", d, 0);
        // falling only on pin 4
        wr(A_RISE, 32'h0); wr(A_FALL, 32'h10);
        pins(28'h10);
        rd(A_PEND, d); chk("R3 rise ignored", d, 0);
        pins(28'h0);
        rd(A_PEND, d); chk("R3 fall latched", d, 32'h10);
        chk("R8 direct line 4", {21'b0, irq_direct}, 32'h10);
        clean();
    endtask

    task automatic t_both_and_none();
        logic [31:0] d;
        wr(A_RISE, 32'h1000); wr(A_FALL, 32'h1000);
        pins(28'h1000);
        rd(A_PEND, d); chk("R4 rise latched", d, 32'h1000);
        chk("R9 summary high", {31'b0, irq_summary}, 1);
        chk("R8 no direct for pin 12", {21'b0, irq_direct}, 0);
        wr(A_PEND, 32'h1000);
        @(negedge clk); chk("R9 summary low after clear", {31'b0, irq_summary}, 0);
        pins(28'h0);
        rd(A_PEND, d); chk("R4 fall latched", d, 32'h1000);
        clean();
        pins(28'h80);
        pins(28'h0);
        rd(A_PEND, d); chk("R5 no enable no latch", d, 0);
        chk("R5 direct low", {21'b0, irq_direct}, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(A_RISE, 32'h0810_0005);
        pins(28'h810_0005);
        rd(A_PEND, d); chk("R6 group latched", d, 32'h0810_0005);
        chk("R8 direct group", {21'b0, irq_direct}, 32'h5);
        chk("R9 summary group", {31'b0, irq_summary}, 1);
        wr(A_PEND, 32'h4);
        @(negedge clk); rd(A_PEND, d); chk("R6 partial clear", d, 32'h0810_0001);
        wr(A_PEND, 32'h0);
        @(negedge clk); rd(A_PEND, d); chk("R6 zero write no effect", d, 32'h0810_0001);
        wr(A_PEND, d);
        @(negedge clk); rd(A_PEND, d); chk("R6 write-back clears all", d, 0);
        chk("R9 summary low", {31'b0, irq_summary}, 0);
        pins(28'h0);
        clean();
    endtask

    task automatic t_retrigger();
        wr(A_RISE, 32'h8000);
        pins(28'h8000);
        chk("R9 first event", {31'b0, irq_summary}, 1);
        wr(A_PEND, 32'h8000);
        @(negedge clk); chk("R9 cleared", {31'b0, irq_summary}, 0);
        pins(28'h0);
        chk("R9 no rise on fall", {31'b0, irq_summary}, 0);
        pins(28'h8000);
        chk("R9 re-raised", {31'b0, irq_summary}, 1);
        pins(28'h0);
        clean();
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        wr(A_RISE, 32'h40); wr(A_FALL, 32'h40);
        pins(28'h40);
        rd(A_PEND, d); chk("R10 prepared", d, 32'h40);
        @(negedge clk); pin_in = 28'h0;
        @(negedge clk);
        @(negedge clk);
        bus_addr = A_PEND; bus_wdata = 32'h40; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd(A_PEND, d); chk("R10 set wins over clear", d, 32'h40);
        wr(A_PEND, 32'h40);
        @(negedge clk); rd(A_PEND, d); chk("R10 later clear works", d, 0);
        clean();
    endtask

    task automatic t_sleep();
        logic [31:0] d;
        wr(A_RISE, 32'h6); wr(A_WAKE, 32'h2);
        @(negedge clk); chk("R11 awake no wake", {31'b0, wake_req}, 0);
        sleep_mode = 1'b1;
        pins(28'h4);
        rd(A_PEND, d); chk("R11 unmasked pin blocked", d, 0);
        chk("R11 wake low", {31'b0, wake_req}, 0);
        pins(28'h6);
        rd(A_PEND, d); chk("R11 masked pin latched", d, 32'h2);
        chk("R11 wake high", {31'b0, wake_req}, 1);
        pins(28'h4);
        rd(A_PEND, d); chk("R11 fall not enabled", d, 32'h2);
        @(negedge clk); sleep_mode = 1'b0;
        #0.5; chk("R11 wake drops when awake", {31'b0, wake_req}, 0);
        pins(28'h0);
        clean();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_single_edges();
        t_both_and_none();
        t_w1c();
        t_retrigger();
        t_set_wins();
        t_sleep();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule